// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries short command words between two ports that run on unrelated clocks, outside the data queue. Port A deposits a word into mailbox 1 for port B to pick up, and port B deposits a word into mailbox 2 for port A. Each mailbox has an active-low full flag, kept in the clock domain of the port that writes it. A write pulls the flag low. A read by the other port sends an acknowledge back across the clock boundary, and that acknowledge returns the flag high. While the flag is low, new writes to that mailbox are refused.

Each port has a mailbox select input that chooses what its output bus carries: the mailbox written by the other port, or the queue output word. The queue itself is not part of this block, so each port has a stub input that stands in for the queue output register. A static bus-size setting narrows the usable mailbox width to 36, 18 or 9 bits.

Top module: `mbox_pair`

## Requirements
- R1: While `rst_n` is low, both flags are high and both mailboxes are cleared to zero. A port with output enable and mailbox select high then reads zero.
- R2: An access counts as a port-A mailbox write when `a_cs`, `a_wr`, `a_en` and `a_mbsel` are all high at a rising `clk_a` edge. If `mb1_full_n` is high at that edge, mailbox 1 loads `a_din` and `mb1_full_n` is low right after the edge.
- R3: An access counts as a port-B mailbox write when `b_cs`, `b_wr`, `b_en` and `b_mbsel` are all high at a rising `clk_b` edge. If `mb2_full_n` is high at that edge, mailbox 2 loads `b_din` and `mb2_full_n` is low right after the edge.
- R4: A mailbox write made while that mailbox's flag is low is ignored, and the stored word does not change.
- R5: A mailbox read is an access with chip select, enable and mailbox select high and the write input low. A port-B read of mailbox 1, made at least two `clk_b` edges after the write, returns `mb1_full_n` high within two `clk_a` edges. A port-A read of mailbox 2 returns `mb2_full_n` high in the same way in the opposite direction.
- R6: Reading a mailbox does not change its contents. Only an accepted write does.
- R7: With `x_oe` low, the output `x_dout` is zero. With `x_oe` high, `x_mbsel` low selects `x_qdata` and `x_mbsel` high selects the mailbox written by the other port.
- R8: `size_sel` sets the usable mailbox width: 0 gives 36 bits, 1 gives bits 0-17, 2 gives bits 0-8, and 3 gives 36 bits. Data inputs above the usable width are ignored, and mailbox outputs above it read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| size_sel | input | 2 | Static usable-width code for the mailboxes |
| a_cs | input | 1 | Port A chip select |
| a_wr | input | 1 | Port A direction, 1 write, 0 read |
| a_en | input | 1 | Port A access enable |
| a_mbsel | input | 1 | Port A mailbox select |
| a_oe | input | 1 | Port A output enable |
| a_din | input | 36 | Port A write data |
| a_qdata | input | 36 | Port A queue output stub |
| a_dout | output | 36 | Port A output bus |
| b_cs | input | 1 | Port B chip select |
| b_wr | input | 1 | Port B direction, 1 write, 0 read |
| b_en | input | 1 | Port B access enable |
| b_mbsel | input | 1 | Port B mailbox select |
| b_oe | input | 1 | Port B output enable |
| b_din | input | 36 | Port B write data |
| b_qdata | input | 36 | Port B queue output stub |
| b_dout | output | 36 | Port B output bus |
| mb1_full_n | output | 1 | Mailbox 1 flag, low while mail is pending (`clk_a` domain) |
| mb2_full_n | output | 1 | Mailbox 2 flag, low while mail is pending (`clk_b` domain) |

## Verification
The bench runs every bus-size code with five word patterns: two mixed values, two alternating-bit values and all ones. It sends each pattern through both mailboxes. The alternating and all-ones patterns put set bits above bit 8 and bit 17, so they show whether the narrow widths are enforced on both the stored and the driven data. Each pattern is followed by a refused overwrite with its inverse, which separates "ignored while full" from "last write wins". A read of the mailbox and then a check of its contents separates a flag release from a cleared register. The queue stub carries a different value from the mailbox, so the select and output-enable checks show which source reaches the bus.

// File: rtl/mbox_pair.sv
module mbox_pair #(
  parameter int DW = 36
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic [1:0]    size_sel,
  input  logic          a_cs,
  input  logic          a_wr,
  input  logic          a_en,
  input  logic          a_mbsel,
  input  logic          a_oe,
  input  logic [DW-1:0] a_din,
  input  logic [DW-1:0] a_qdata,
  output logic [DW-1:0] a_dout,
  input  logic          b_cs,
  input  logic          b_wr,
  input  logic          b_en,
  input  logic          b_mbsel,
  input  logic          b_oe,
  input  logic [DW-1:0] b_din,
  input  logic [DW-1:0] b_qdata,
  output logic [DW-1:0] b_dout,
  output logic          mb1_full_n,
  output logic          mb2_full_n
);

  localparam int HW = DW / 2;
  localparam int QW = DW / 4;

  logic [DW-1:0] mask;
  logic [DW-1:0] mb1, mb2;
  logic          mb1_req, mb1_ack, mb2_req, mb2_ack;
  logic [1:0]    mb1_ack_s, mb1_req_s, mb2_ack_s, mb2_req_s;
  logic          a_mb_wr, a_mb_rd, b_mb_wr, b_mb_rd;

  always_comb begin
    case (size_sel)
      2'd1:    mask = {{(DW-HW){1'b0}}, {HW{1'b1}}};
      2'd2:    mask = {{(DW-QW){1'b0}}, {QW{1'b1}}};
      default: mask = {DW{1'b1}};
    endcase
  end

  assign a_mb_wr = a_cs & a_wr & a_en & a_mbsel;
  assign a_mb_rd = a_cs & ~a_wr & a_en & a_mbsel;
  assign b_mb_wr = b_cs & b_wr & b_en & b_mbsel;
  assign b_mb_rd = b_cs & ~b_wr & b_en & b_mbsel;

  assign mb1_full_n = (mb1_req == mb1_ack_s[1]);
  assign mb2_full_n = (mb2_req == mb2_ack_s[1]);

  // Port A domain: mailbox 1 writer, mailbox 2 reader
  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      mb1       <= '0;
      mb1_req   <= 1'b0;
      mb1_ack_s <= 2'b00;
      mb2_req_s <= 2'b00;
      mb2_ack   <= 1'b0;
    end else begin
      mb1_ack_s <= {mb1_ack_s[0], mb1_ack};
      mb2_req_s <= {mb2_req_s[0], mb2_req};
      if (a_mb_wr && mb1_full_n) begin
        mb1     <= a_din & mask;
        mb1_req <= ~mb1_req;
      end
      if (a_mb_rd && (mb2_req_s[1] != mb2_ack))
        mb2_ack <= ~mb2_ack;
    end
  end

  // Port B domain: mailbox 2 writer, mailbox 1 reader
  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      mb2       <= '0;
      mb2_req   <= 1'b0;
      mb2_ack_s <= 2'b00;
      mb1_req_s <= 2'b00;
      mb1_ack   <= 1'b0;
    end else begin
      mb2_ack_s <= {mb2_ack_s[0], mb2_ack};
      mb1_req_s <= {mb1_req_s[0], mb1_req};
      if (b_mb_wr && mb2_full_n) begin
        mb2     <= b_din & mask;
        mb2_req <= ~mb2_req;
      end
      if (b_mb_rd && (mb1_req_s[1] != mb1_ack))
        mb1_ack <= ~mb1_ack;
    end
  end

  assign a_dout = !a_oe ? '0 : (a_mbsel ? (mb2 & mask) : a_qdata);
  assign b_dout = !b_oe ? '0 : (b_mbsel ? (mb1 & mask) : b_qdata);

  AST_MB1_LOAD: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_mb_wr && mb1_full_n) |=> (!mb1_full_n && mb1 == ($past(a_din) & mask))); // R2
  AST_MB2_LOAD: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_mb_wr && mb2_full_n) |=> (!mb2_full_n && mb2 == ($past(b_din) & mask))); // R3
  AST_MB1_REFUSE: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_mb_wr && !mb1_full_n) |=> $stable(mb1)); // R4
  AST_MB2_REFUSE: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_mb_wr && !mb2_full_n) |=> $stable(mb2)); // R4
  AST_MB1_READ_KEEP: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_mb_rd && (mb1_req_s[1] != mb1_ack)) |=> $stable(mb1)); // R6
  AST_MB2_READ_KEEP: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_mb_rd && (mb2_req_s[1] != mb2_ack)) |=> $stable(mb2)); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk_a) disable iff (!rst_n)
    ((mb1 & ~mask) == '0) && ((mb2 & ~mask) == '0)); // R8

endmodule

// File: tb/mbox_pair_tb.sv
module mbox_pair_tb;
  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic [1:0] size_sel = 2'd0;
  logic a_cs = 0, a_wr = 0, a_en = 0, a_mbsel = 1, a_oe = 1;
  logic b_cs = 0, b_wr = 0, b_en = 0, b_mbsel = 1, b_oe = 1;
  logic [35:0] a_din = '0, a_qdata = '0, b_din = '0, b_qdata = '0;
  logic [35:0] a_dout, b_dout;
  logic mb1_full_n, mb2_full_n;
  int vecs = 0, errs = 0;

  always #10 clk_a = ~clk_a;
  always #13 clk_b = ~clk_b;

  mbox_pair #(.DW(36)) u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .size_sel(size_sel),
    .a_cs(a_cs), .a_wr(a_wr), .a_en(a_en), .a_mbsel(a_mbsel), .a_oe(a_oe),
    .a_din(a_din), .a_qdata(a_qdata), .a_dout(a_dout),
    .b_cs(b_cs), .b_wr(b_wr), .b_en(b_en), .b_mbsel(b_mbsel), .b_oe(b_oe),
    .b_din(b_din), .b_qdata(b_qdata), .b_dout(b_dout),
    .mb1_full_n(mb1_full_n), .mb2_full_n(mb2_full_n));

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_a(input logic [35:0] d);
    @(negedge clk_a); a_cs = 1; a_wr = 1; a_en = 1; a_din = d;
    @(negedge clk_a); a_en = 0; a_wr = 0;
  endtask
  task automatic wr_b(input logic [35:0] d);
    @(negedge clk_b); b_cs = 1; b_wr = 1; b_en = 1; b_din = d;
    @(negedge clk_b); b_en = 0; b_wr = 0;
  endtask
  task automatic rd_a();
    @(negedge clk_a); a_cs = 1; a_wr = 0; a_en = 1;
    @(negedge clk_a); a_en = 0;
  endtask
  task automatic rd_b();
    @(negedge clk_b); b_cs = 1; b_wr = 0; b_en = 1;
    @(negedge clk_b); b_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_a); rst_n = 0;
    chk("R1 mb1 flag in reset", {35'd0, mb1_full_n}, 36'd1);
    chk("R1 mb2 flag in reset", {35'd0, mb2_full_n}, 36'd1);
    repeat (3) @(negedge clk_a);
    rst_n = 1;
    repeat (3) @(negedge clk_b);
    chk("R1 a_dout after reset", a_dout, '0);
    chk("R1 b_dout after reset", b_dout, '0);
  endtask

  initial begin
    #(20 * 200000);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [35:0] pats [5];
    pats[0] = 36'h123456789; pats[1] = 36'hFEDCBA987;
    pats[2] = 36'hAAAAAAAAA; pats[3] = 36'h555555555; pats[4] = 36'hFFFFFFFFF;
    for (int s = 0; s < 4; s++) begin
      int w;
      logic [35:0] m;
      size_sel = s[1:0];
      w = (s == 1) ? 18 : (s == 2) ? 9 : 36;
      m = {36{1'b1}} >> (36 - w);
      do_reset();
      for (int p = 0; p < 5; p++) begin
        logic [35:0] d;
        d = pats[p];
        // mailbox 1: A -> B
        wr_a(d);
        chk("R2 mb1 flag low after write", {35'd0, mb1_full_n}, 36'd0);
        chk("R2/R8 b_dout mailbox 1", b_dout, d & m);
        wr_a(~d);
        repeat (4) @(negedge clk_b);
        chk("R4 mb1 refused overwrite", b_dout, d & m);
        rd_b();
        repeat (4) @(negedge clk_a);
        chk("R5 mb1 flag high after read", {35'd0, mb1_full_n}, 36'd1);
        chk("R6 mb1 kept after read", b_dout, d & m);
        // mailbox 2: B -> A
        wr_b(~d);
        chk("R3 mb2 flag low after write", {35'd0, mb2_full_n}, 36'd0);
        #1 chk("R3/R8 a_dout mailbox 2", a_dout, ~d & m);
        wr_b(d);
        repeat (4) @(negedge clk_a);
        chk("R4 mb2 refused overwrite", a_dout, ~d & m);
        rd_a();
        repeat (4) @(negedge clk_b);
        chk("R5 mb2 flag high after read", {35'd0, mb2_full_n}, 36'd1);
        chk("R6 mb2 kept after read", a_dout, ~d & m);
        // output selection
        a_qdata = d ^ 36'h0F0F0F0F0; b_qdata = ~d;
        a_mbsel = 0; b_mbsel = 0; #1;
        chk("R7 a_dout queue path", a_dout, d ^ 36'h0F0F0F0F0);
        chk("R7 b_dout queue path", b_dout, ~d);
        a_oe = 0; b_oe = 0; #1;
        chk("R7 a_dout disabled", a_dout, '0);
        chk("R7 b_dout disabled", b_dout, '0);
        a_oe = 1; b_oe = 1; a_mbsel = 1; b_mbsel = 1; #1;
        chk("R7 a_dout mailbox path", a_dout, ~d & m);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule